// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router with Dimension-Ordered Routing

This block is the switching element of one tile in a two-dimensional mesh. It has five bidirectional ports: one toward the tile's own core (Local) and one toward each compass neighbour (East, West, North, South). Every port carries one flit per transfer, using a valid/ready handshake. The router's own X and Y coordinates are fixed parameters. Columns grow toward East, and rows grow toward South.

Each flit that arrives is written into a small FIFO on its input. When a head flit reaches the front of a FIFO, the router reads the destination from that flit. It resolves the X difference first and the Y difference second, then asks for the selected output. A round-robin arbiter on each output picks one requesting input and locks the output to it. The rest of that packet streams through the crossbar to that output. No other packet can use the output until the tail flit has been accepted downstream. A packet made of a single flit takes the output and releases it in the same transfer.

Flit layout for the default width of 16 bits:
- Bits [15:14] hold the kind: 01 head, 00 body, 10 tail, 11 single-flit packet.
- Bit 15 set marks the end of a packet. Bit 14 set marks a flit that carries a route.
- In a head flit, bits [1:0] hold the destination X and bits [3:2] hold the destination Y.

Top module: `mesh_xy_router`

## Requirements
- R1: After reset, every out_valid is 0 and every in_ready is 1 (all FIFOs are empty and no output is owned).
- R2: A head flit whose destination X and Y (bits [1:0] and [3:2]) equal the router's own coordinates leaves on the Local port (index 0).
- R3: A head flit whose destination X is greater than the router's X leaves on East (index 1). If it is smaller, the flit leaves on West (index 2). This holds whatever the Y field says.
- R4: When the X fields match, a destination Y greater than the router's Y goes South (index 4), and a smaller one goes North (index 3).
- R5: All flits of one packet leave on the head's output, in arrival order. No flit of another packet appears on that output between the head and the tail.
- R6: While an output has out_valid high and out_ready low, it keeps out_valid high and out_flit unchanged. The packet's flits behind it stay blocked.
- R7: Each output grants its requesting inputs in round-robin order, starting after the most recent winner. An input that has just been served yields to another waiting input.
- R8: A flit of kind 11 is a complete packet. It claims its output and releases it in one transfer, so the next packet can then use that output.
- R9: Each input FIFO holds 4 flits. With no flit drained from an input, that input accepts exactly 4 flits and then holds in_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per input port: a flit is offered (bit 0 Local, 1 East, 2 West, 3 North, 4 South) |
| in_ready | output | 5 | Per input port: the FIFO has room |
| in_flit | input | 80 | Five 16-bit flits, port p at bits [16p+15:16p] |
| out_valid | output | 5 | Per output port: a flit is presented |
| out_ready | input | 5 | Per output port: the downstream side accepts the flit |
| out_flit | output | 80 | Five 16-bit flits, port p at bits [16p+15:16p] |

## Verification
The two functions that can fall into the same cycle are path locking and arbitration. These are a packet still holding an output and fresh heads from other inputs requesting that output, and two heads from different inputs requesting the same output. The bench provokes the clash by stalling the West output while two packets from East and one from South queue for it. It then releases the output and requires the order East, South, East. A fixed-priority arbiter would produce a different order, and any interleaving of flits would break the per-packet order that the bench's model tracks. A mixed phase with random out_ready on all ports repeats these collisions, and every flit leaving the block is compared on the clock it is transferred.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int NPORT  = 5;
  localparam int PIDX_W = 3;

  localparam logic [PIDX_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PIDX_W-1:0] PORT_EAST  = 3'd1;
  localparam logic [PIDX_W-1:0] PORT_WEST  = 3'd2;
  localparam logic [PIDX_W-1:0] PORT_NORTH = 3'd3;
  localparam logic [PIDX_W-1:0] PORT_SOUTH = 3'd4;

  // kind field in the two top bits of every flit
  localparam logic [1:0] KIND_BODY = 2'b00;
  localparam logic [1:0] KIND_HEAD = 2'b01;
  localparam logic [1:0] KIND_TAIL = 2'b10;
  localparam logic [1:0] KIND_SOLO = 2'b11;
endpackage

// File: rtl/rt_fifo.sv
module rt_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      fill;

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   fill <= fill + (AW+1)'(1);
        2'b01:   fill <= fill - (AW+1)'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign rd_data = store[rd_ptr];
  assign empty   = (fill == '0);
  assign full    = (fill == (AW+1)'(DEPTH));
endmodule

// File: rtl/rt_xy_route.sv
module rt_xy_route import rt_pkg::*; #(
  parameter int CRD_W = 2,
  parameter int MY_X  = 1,
  parameter int MY_Y  = 1
) (
  input  logic [2*CRD_W-1:0] dest,
  output logic [NPORT-1:0]   dir_oh
);
  localparam logic [CRD_W-1:0] HERE_X = CRD_W'(MY_X);
  localparam logic [CRD_W-1:0] HERE_Y = CRD_W'(MY_Y);

  logic [CRD_W-1:0] dx, dy;
  assign dx = dest[CRD_W-1:0];
  assign dy = dest[2*CRD_W-1:CRD_W];

  // X first, then Y; Y grows toward South
  always_comb begin
    dir_oh = '0;
    if (dx > HERE_X)      dir_oh[PORT_EAST]  = 1'b1;
    else if (dx < HERE_X) dir_oh[PORT_WEST]  = 1'b1;
    else if (dy > HERE_Y) dir_oh[PORT_SOUTH] = 1'b1;
    else if (dy < HERE_Y) dir_oh[PORT_NORTH] = 1'b1;
    else                  dir_oh[PORT_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/rt_rr_arb.sv
module rt_rr_arb #(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic                 any,
  output logic [$clog2(N)-1:0] win
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;

  always_comb begin
    int c;
    any = 1'b0;
    win = '0;
    for (int k = 0; k < N; k++) begin
      c = (int'(ptr_q) + k) % N;
      if (!any && req[c]) begin
        any = 1'b1;
        win = IW'(c);
      end
    end
  end

  // search starts one past the last winner
  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (take && any) ptr_q <= (win == IW'(N-1)) ? '0 : win + IW'(1);
  end
endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router import rt_pkg::*; #(
  parameter int FLIT_W    = 16,
  parameter int CRD_W     = 2,
  parameter int MY_X      = 1,
  parameter int MY_Y      = 1,
  parameter int BUF_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready,
  output logic [NPORT*FLIT_W-1:0] out_flit
);
  localparam int TAIL_BIT = FLIT_W - 1;
  localparam int HEAD_BIT = FLIT_W - 2;

  logic [FLIT_W-1:0] front   [NPORT];
  logic [NPORT-1:0]  f_empty, f_full, f_pop, f_push, busy_in;
  logic [NPORT-1:0]  dir_oh  [NPORT];
  logic [NPORT-1:0]  req_to  [NPORT];
  logic [NPORT-1:0]  arb_any, xfer;
  logic [PIDX_W-1:0] arb_win [NPORT];
  logic [NPORT-1:0]  lock_q;
  logic [PIDX_W-1:0] owner_q [NPORT];

  // input side: buffer and route unit per port
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assign in_ready[i] = !f_full[i];
    assign f_push[i]   = in_valid[i] && !f_full[i];

    rt_fifo #(.WIDTH(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (f_push[i]),
      .wr_data (in_flit[i*FLIT_W +: FLIT_W]),
      .rd_en   (f_pop[i]),
      .rd_data (front[i]),
      .empty   (f_empty[i]),
      .full    (f_full[i])
    );

    rt_xy_route #(.CRD_W(CRD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dest   (front[i][2*CRD_W-1:0]),
      .dir_oh (dir_oh[i])
    );
  end

  // an input already holding an output does not request again
  always_comb begin
    busy_in = '0;
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        if (lock_q[o] && owner_q[o] == PIDX_W'(i)) busy_in[i] = 1'b1;
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req_to[o][i] = !f_empty[i] && front[i][HEAD_BIT] && !busy_in[i] && dir_oh[i][o];
  end

  // output side: arbiter, crossbar leg and ownership lock per port
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    rt_rr_arb #(.N(NPORT)) u_arb (
      .clk  (clk),
      .rst  (rst),
      .req  (req_to[o]),
      .take (!lock_q[o]),
      .any  (arb_any[o]),
      .win  (arb_win[o])
    );

    assign out_valid[o] = lock_q[o] && !f_empty[owner_q[o]];
    assign out_flit[o*FLIT_W +: FLIT_W] = front[owner_q[o]];
    assign xfer[o] = out_valid[o] && out_ready[o];

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_q[o]  <= 1'b0;
        owner_q[o] <= '0;
      end else if (lock_q[o]) begin
        if (xfer[o] && front[owner_q[o]][TAIL_BIT]) lock_q[o] <= 1'b0;
      end else if (arb_any[o]) begin
        lock_q[o]  <= 1'b1;
        owner_q[o] <= arb_win[o];
      end
    end
  end

  always_comb begin
    f_pop = '0;
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        if (xfer[o] && owner_q[o] == PIDX_W'(i)) f_pop[i] = 1'b1;
  end
endmodule

// File: rtl/rt_router_chk.sv
module rt_router_chk import rt_pkg::*; #(
  parameter int FLIT_W = 16,
  parameter int CRD_W  = 2,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPORT-1:0]        in_ready,
  input logic [NPORT-1:0]        out_valid,
  input logic [NPORT-1:0]        out_ready,
  input logic [NPORT*FLIT_W-1:0] out_flit,
  input logic [NPORT-1:0]        lock_q,
  input logic [PIDX_W-1:0]       owner_q [NPORT]
);
  function automatic int want_port(input logic [CRD_W-1:0] dx, input logic [CRD_W-1:0] dy);
    if (int'(dx) != MY_X) return (int'(dx) > MY_X) ? 1 : 2;
    if (int'(dy) != MY_Y) return (int'(dy) > MY_Y) ? 4 : 3;
    return 0;
  endfunction

  logic [NPORT-1:0] owned [NPORT];
  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        owned[i][o] = lock_q[o] && owner_q[o] == PIDX_W'(i);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_valid == '0 && in_ready == '1));

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    // R6
    hold_flit_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W])));
    // R8
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && out_ready[o] && out_flit[o*FLIT_W + FLIT_W - 1]) |=> !out_valid[o]);
    // R2 R3 R4
    route_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && out_flit[o*FLIT_W + FLIT_W - 2]) |->
        (want_port(out_flit[o*FLIT_W +: CRD_W], out_flit[o*FLIT_W + CRD_W +: CRD_W]) == o));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(owned[i]));
  end
endmodule

bind mesh_xy_router rt_router_chk #(
  .FLIT_W (FLIT_W),
  .CRD_W  (CRD_W),
  .MY_X   (MY_X),
  .MY_Y   (MY_Y)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit),
  .lock_q    (lock_q),
  .owner_q   (owner_q)
);

// File: tb/sim_mesh_xy_router.sv
module sim_mesh_xy_router;
  localparam int W  = 16;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]   in_valid  = '0;
  logic [NP-1:0]   in_ready;
  logic [NP*W-1:0] in_flit   = '0;
  logic [NP-1:0]   out_valid;
  logic [NP-1:0]   out_ready = '0;
  logic [NP*W-1:0] out_flit;

  always #10 clk = ~clk;   // 50 MHz

  mesh_xy_router u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  logic [W-1:0] src_q [NP][$];
  logic [W-1:0] exp_q [NP][NP][$];
  int           grant_log [NP][$];
  int           cur_src [NP];
  int           acc_cnt [NP];
  logic [NP-1:0] acc_prev = '0;
  logic [NP-1:0] hold_rdy = '0;
  bit           rand_rdy = 0;
  logic [15:0]  lfsr = 16'hACE1;
  logic [9:0]   next_id = '0;
  int tests = 0, fails = 0, cyc = 0;

  function automatic int ref_port(input int dx, input int dy);
    if (dx > 1) return 1;
    if (dx < 1) return 2;
    if (dy > 1) return 4;
    if (dy < 1) return 3;
    return 0;
  endfunction

  function automatic string port_req(input int o);
    if (o == 0) return "R2";
    if (o <= 2) return "R3";
    return "R4";
  endfunction

  task automatic send_pkt(input int src, input int dx, input int dy, input int len);
    int p;
    logic [1:0] kind;
    logic [3:0] low;
    logic [W-1:0] f;
    p = ref_port(dx, dy);
    for (int k = 0; k < len; k++) begin
      if (len == 1)           kind = 2'b11;
      else if (k == 0)        kind = 2'b01;
      else if (k == len - 1)  kind = 2'b10;
      else                    kind = 2'b00;
      low = (k == 0) ? {2'(dy), 2'(dx)} : 4'(k);
      f = {kind, next_id, low};
      src_q[src].push_back(f);
      exp_q[src][p].push_back(f);
    end
    next_id = next_id + 10'd1;
  endtask

  // behavioural model: per output, packets must arrive whole and in per-source order
  task automatic model_check(input int o, input logic [W-1:0] f);
    int found;
    logic [W-1:0] e;
    tests++;
    if (cur_src[o] < 0) begin
      found = -1;
      for (int i = 0; i < NP; i++)
        if (found < 0 && exp_q[i][o].size() > 0 && exp_q[i][o][0] == f && f[W-2]) found = i;
      if (found < 0) begin
        fails++;
        e = 'x;
        for (int i = NP - 1; i >= 0; i--) if (exp_q[i][o].size() > 0) e = exp_q[i][o][0];
        $display("FAIL %s/R5: port %0d delivered %h, expected a queued head such as %h",
                 port_req(o), o, f, e);
      end else begin
        void'(exp_q[found][o].pop_front());
        grant_log[o].push_back(found);
        if (!f[W-1]) cur_src[o] = found;
      end
    end else begin
      e = (exp_q[cur_src[o]][o].size() > 0) ? exp_q[cur_src[o]][o][0] : 'x;
      if (f !== e) begin
        fails++;
        $display("FAIL R5: port %0d delivered %h, expected %h", o, f, e);
      end else void'(exp_q[cur_src[o]][o].pop_front());
      if (f[W-1]) cur_src[o] = -1;
    end
  endtask

  // drive on the falling edge, sample 5 ns later, well before the rising edge
  always begin
    @(negedge clk);
    if (rst) begin
      in_valid  = '0;
      out_ready = '0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int i = 0; i < NP; i++) begin
        if (acc_prev[i]) void'(src_q[i].pop_front());
        in_valid[i] = (src_q[i].size() > 0);
        in_flit[i*W +: W] = (src_q[i].size() > 0) ? src_q[i][0] : '0;
      end
      for (int o = 0; o < NP; o++)
        out_ready[o] = !hold_rdy[o] && (!rand_rdy || lfsr[o+3]);
    end
    #5;
    for (int i = 0; i < NP; i++) begin
      acc_prev[i] = !rst && in_valid[i] && in_ready[i];
      if (acc_prev[i]) acc_cnt[i]++;
    end
    for (int o = 0; o < NP; o++)
      if (!rst && out_valid[o] && out_ready[o]) model_check(o, out_flit[o*W +: W]);
  end

  function automatic bit all_done();
    for (int i = 0; i < NP; i++) begin
      if (src_q[i].size() != 0 || cur_src[i] >= 0) return 0;
      for (int o = 0; o < NP; o++) if (exp_q[i][o].size() != 0) return 0;
    end
    return 1;
  endfunction

  task automatic wait_drain(input string rq, input int lim);
    int left;
    for (int k = 0; k < lim && !all_done(); k++) @(posedge clk);
    left = 0;
    for (int i = 0; i < NP; i++)
      for (int o = 0; o < NP; o++) left += exp_q[i][o].size();
    tests++;
    if (!all_done()) begin
      fails++;
      $display("FAIL %s: %0d flits undelivered, expected 0", rq, left);
    end
  endtask

  task automatic check(input string rq, input bit ok, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] head;
    int base, lg;
    for (int i = 0; i < NP; i++) begin cur_src[i] = -1; acc_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk); #6;
    check("R1 out_valid", out_valid == '0, W'(out_valid), '0);
    check("R1 in_ready", in_ready == '1, W'(in_ready), W'(5'h1f));

    // R2 R3 R4: every destination of a 3x3 mesh from the Local input
    @(posedge clk);
    for (int dy = 0; dy < 3; dy++)
      for (int dx = 0; dx < 3; dx++) send_pkt(0, dx, dy, 3);
    wait_drain("R2/R3/R4 route sweep", 2000);

    // R9 and R6: Local output stalled, six-flit packet from North
    @(posedge clk);
    hold_rdy[0] = 1'b1;
    base = acc_cnt[3];
    send_pkt(3, 1, 1, 6);
    head = exp_q[3][0][0];
    repeat (15) @(posedge clk);
    @(negedge clk); #6;
    check("R9 accepted count", (acc_cnt[3] - base) == 4, W'(acc_cnt[3] - base), 16'd4);
    check("R9 in_ready low when full", in_ready[3] == 1'b0, W'(in_ready[3]), 16'd0);
    check("R6 out_valid held", out_valid[0] == 1'b1, W'(out_valid[0]), 16'd1);
    check("R6 head flit held", out_flit[0 +: W] == head, out_flit[0 +: W], head);
    @(posedge clk);
    hold_rdy[0] = 1'b0;
    wait_drain("R9 drain after stall", 500);

    // R7: West stalled, East sends two packets and South one, all westward
    @(posedge clk);
    hold_rdy[2] = 1'b1;
    lg = grant_log[2].size();
    send_pkt(1, 0, 1, 3);
    send_pkt(1, 0, 1, 3);
    send_pkt(4, 0, 1, 3);
    repeat (10) @(posedge clk);
    hold_rdy[2] = 1'b0;
    wait_drain("R7 drain", 500);
    check("R7 grant count", grant_log[2].size() == lg + 3, W'(grant_log[2].size() - lg), 16'd3);
    if (grant_log[2].size() == lg + 3) begin
      check("R7 first winner East", grant_log[2][lg] == 1, W'(grant_log[2][lg]), 16'd1);
      check("R7 South before East again", grant_log[2][lg+1] == 4, W'(grant_log[2][lg+1]), 16'd4);
      check("R7 East last", grant_log[2][lg+2] == 1, W'(grant_log[2][lg+2]), 16'd1);
    end

    // R8: single-flit packets share East with a three-flit packet
    @(posedge clk);
    lg = grant_log[1].size();
    send_pkt(0, 2, 1, 1);
    send_pkt(2, 2, 0, 3);
    send_pkt(0, 2, 2, 1);
    wait_drain("R8 drain", 500);
    check("R8 three packets on East", grant_log[1].size() == lg + 3,
          W'(grant_log[1].size() - lg), 16'd3);

    // R5: all inputs busy, mixed lengths, random back-pressure
    @(posedge clk);
    rand_rdy = 1;
    for (int r = 0; r < 6; r++)
      for (int s = 0; s < NP; s++)
        send_pkt(s, (s + r) % 3, (2 * s + r) % 3, 1 + (s + r) % 4);
    wait_drain("R5 mixed traffic", 5000);
    rand_rdy = 0;

    repeat (5) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule